// File: doc/BRIEF.md
# Receive Signaling Serial Output Buffer

This block keeps one multiframe's worth of per-channel robbed-bit or channel-associated signaling. It replays that signaling on a dedicated serial pin, aligned bit for bit with the receive serial data stream. Upstream logic delivers a 4-bit ABCD nibble per channel through a simple write port. A frame position (framing-bit flag, channel number, bit number) is presented every bit time. The block answers with the signaling bit that belongs to that bit time.

Storage is double-buffered. Nibbles land in a shadow copy. A multiframe strobe moves the shadow copy into the output copy in one cycle, so the serial output never mixes two multiframes. A freeze input makes the block skip that transfer, and the last good signaling keeps playing. Three framing modes are supported: 24-channel extended superframe, 24-channel superframe (A and B bits only, each sent twice), and 32-timeslot E1 with channel-associated signaling.

Top module: `rxsig_serial_buf`

## Requirements
- R1: While reset (`rst_n` low) is applied and in the cycle after its release, `sig_out` is 0. Both copies of the buffer are cleared, so a strobe with no write before it keeps `sig_out` at 0.
- R2: `sig_out` is registered. It shows the bit for the position presented one clock earlier. A position is `pos_ch`, plus `pos_bit` 0..7 for channel bits 1..8 (bit 1 is sent first).
- R3: `mode` 2'b00 is T1 extended superframe. At `pos_bit` 4, 5, 6 and 7, `sig_out` carries A, B, C and D of that channel. A is nibble bit 3 and D is nibble bit 0.
- R4: `mode` 2'b01 is T1 superframe. At `pos_bit` 4, 5, 6 and 7, `sig_out` carries A, B, A and B (nibble bits 3, 2, 3, 2). C and D are never sent.
- R5: `mode` 2'b10 is E1 with channel-associated signaling. Timeslots 1..15 and 17..31 carry A, B, C and D as in R3. Timeslots 0 and 16 give 0. `pos_fbit` has no effect in this mode. `mode` 2'b11 gives 0 everywhere.
- R6: At `pos_bit` 0..3 (the upper nibble of any channel), `sig_out` is 0.
- R7: In both T1 modes, `sig_out` is 0 when `pos_fbit` is 1 (the framing bit), and for channel numbers 24 and above.
- R8: A nibble written with `wr_en` changes nothing on `sig_out` until a `mf_strobe` cycle with `freeze` low. From the cycle after that strobe, it is on the output.
- R9: A `mf_strobe` with `freeze` high leaves the output copy unchanged. The pending shadow contents are kept, and a later strobe without freeze transfers them.
- R10: A write made in the same cycle as a strobe goes to the shadow copy only. It reaches the output at the next unfrozen strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Framing mode: 00 T1 ESF, 01 T1 SF, 10 E1 CAS, 11 off |
| wr_en | input | 1 | Write a nibble into the shadow copy |
| wr_ch | input | 5 | Channel written |
| wr_nib | input | 4 | ABCD nibble, A in bit 3 |
| mf_strobe | input | 1 | Multiframe boundary: transfer shadow to output copy |
| freeze | input | 1 | Block the transfer at a strobe |
| pos_fbit | input | 1 | Current bit time is the T1 framing bit |
| pos_ch | input | 5 | Current channel or timeslot |
| pos_bit | input | 3 | Current bit within the channel, 0 = bit 1 |
| sig_out | output | 1 | Serial signaling output |

## Verification
A wrong value in the output copy appears on `sig_out` one clock after the affected channel's lower nibble is addressed. That happens at most one frame later in live traffic. A lost or early shadow-to-output transfer, or a freeze that leaks, shows up from the cycle after the strobe. It is caught by scanning a channel whose nibble differs between the old and new contents. A mode decode error shows as a C or D bit, or a repeated A or B bit, in the wrong bit slot. Such an error is visible on the very next addressed lower-nibble bit.

// File: rtl/rxsig_pkg.sv
package rxsig_pkg;
   typedef enum logic [1:0] {
      FM_T1_ESF = 2'b00,
      FM_T1_SF  = 2'b01,
      FM_E1_CAS = 2'b10,
      FM_OFF    = 2'b11
   } frm_mode_t;
endpackage

// File: rtl/rxsig_shadow_bank.sv
module rxsig_shadow_bank #(
   parameter int MAX_CH = 32,
   parameter int NIB_W  = 4,
   localparam int CH_W  = $clog2(MAX_CH),
   localparam int VEC_W = MAX_CH * NIB_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CH_W-1:0]  wr_ch,
   input  logic [NIB_W-1:0] wr_nib,
   output logic [VEC_W-1:0] shadow
);
   for (genvar g = 0; g < MAX_CH; g++) begin : g_slot
      logic hit;
      assign hit = wr_en && (wr_ch == CH_W'(g));
      always_ff @(posedge clk) begin
         if (!rst_n)
            shadow[g*NIB_W +: NIB_W] <= '0;
         else if (hit)
            shadow[g*NIB_W +: NIB_W] <= wr_nib;
      end
   end
endmodule

// File: rtl/rxsig_active_bank.sv
module rxsig_active_bank #(
   parameter int MAX_CH = 32,
   parameter int NIB_W  = 4,
   localparam int VEC_W = MAX_CH * NIB_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [VEC_W-1:0] shadow,
   output logic [VEC_W-1:0] active
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         active <= '0;
      else if (load)
         active <= shadow;
   end
endmodule

// File: rtl/rxsig_bit_sel.sv
module rxsig_bit_sel
   import rxsig_pkg::*;
#(
   parameter int MAX_CH = 32,
   parameter int NIB_W  = 4,
   parameter int T1_CH  = 24,
   parameter int E1_SIG_TS = 16,
   localparam int CH_W  = $clog2(MAX_CH),
   localparam int VEC_W = MAX_CH * NIB_W
) (
   input  logic [1:0]       mode,
   input  logic             pos_fbit,
   input  logic [CH_W-1:0]  pos_ch,
   input  logic [2:0]       pos_bit,
   input  logic [VEC_W-1:0] active,
   output logic             bit_d
);
   logic [MAX_CH-1:0] t1_ok;
   logic [MAX_CH-1:0] e1_ok;

   for (genvar g = 0; g < MAX_CH; g++) begin : g_mask
      assign t1_ok[g] = (g < T1_CH);
      assign e1_ok[g] = (g != 0) && (g != E1_SIG_TS);
   end

   logic [NIB_W-1:0] nib;
   logic [1:0]       idx;
   logic             low_half;
   logic             esf_bit;
   logic             sf_bit;

   assign nib      = active[pos_ch*NIB_W +: NIB_W];
   assign idx      = pos_bit[1:0];
   assign low_half = pos_bit[2];
   assign esf_bit  = nib[2'd3 - idx];
   assign sf_bit   = nib[2'd3 - {1'b0, idx[0]}];

   always_comb begin
      bit_d = 1'b0;
      if (low_half) begin
         unique case (frm_mode_t'(mode))
            FM_T1_ESF: bit_d = !pos_fbit && t1_ok[pos_ch] && esf_bit;
            FM_T1_SF:  bit_d = !pos_fbit && t1_ok[pos_ch] && sf_bit;
            FM_E1_CAS: bit_d = e1_ok[pos_ch] && esf_bit;
            default:   bit_d = 1'b0;
         endcase
      end
   end
endmodule

// File: rtl/rxsig_serial_buf.sv
module rxsig_serial_buf #(
   parameter int MAX_CH    = 32,
   parameter int NIB_W     = 4,
   parameter int T1_CH     = 24,
   parameter int E1_SIG_TS = 16,
   localparam int CH_W     = $clog2(MAX_CH),
   localparam int VEC_W    = MAX_CH * NIB_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       mode,
   input  logic             wr_en,
   input  logic [CH_W-1:0]  wr_ch,
   input  logic [NIB_W-1:0] wr_nib,
   input  logic             mf_strobe,
   input  logic             freeze,
   input  logic             pos_fbit,
   input  logic [CH_W-1:0]  pos_ch,
   input  logic [2:0]       pos_bit,
   output logic             sig_out
);
   initial begin
      assert (NIB_W == 4) else $error("NIB_W must be 4");
      assert (MAX_CH == 32) else $error("MAX_CH must be 32");
      assert (T1_CH < MAX_CH) else $error("T1_CH out of range");
      assert (E1_SIG_TS < MAX_CH) else $error("E1_SIG_TS out of range");
   end

   logic [VEC_W-1:0] shadow;
   logic [VEC_W-1:0] active;
   logic             load;
   logic             bit_d;

   assign load = mf_strobe && !freeze;

   rxsig_shadow_bank #(.MAX_CH(MAX_CH), .NIB_W(NIB_W)) u_shadow (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch),
      .wr_nib(wr_nib), .shadow(shadow)
   );

   rxsig_active_bank #(.MAX_CH(MAX_CH), .NIB_W(NIB_W)) u_active (
      .clk(clk), .rst_n(rst_n), .load(load), .shadow(shadow),
      .active(active)
   );

   rxsig_bit_sel #(.MAX_CH(MAX_CH), .NIB_W(NIB_W), .T1_CH(T1_CH),
                   .E1_SIG_TS(E1_SIG_TS)) u_sel (
      .mode(mode), .pos_fbit(pos_fbit), .pos_ch(pos_ch),
      .pos_bit(pos_bit), .active(active), .bit_d(bit_d)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         sig_out <= 1'b0;
      else
         sig_out <= bit_d;
   end
endmodule

// File: rtl/rxsig_chk.sv
module rxsig_chk #(
   parameter int MAX_CH = 32,
   parameter int NIB_W  = 4,
   localparam int CH_W  = $clog2(MAX_CH),
   localparam int VEC_W = MAX_CH * NIB_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       mode,
   input logic             mf_strobe,
   input logic             freeze,
   input logic             pos_fbit,
   input logic [CH_W-1:0]  pos_ch,
   input logic [2:0]       pos_bit,
   input logic [VEC_W-1:0] active,
   input logic             sig_out
);
   AST_UPPER_NIBBLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !pos_bit[2] |=> !sig_out); // R6

   AST_FBIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (pos_fbit && !mode[1]) |=> !sig_out); // R7

   AST_E1_TS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b10 && (pos_ch == 0 || pos_ch == 16)) |=> !sig_out); // R5

   AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      freeze |=> $stable(active)); // R9

   AST_NO_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !mf_strobe |=> $stable(active)); // R8
endmodule

bind rxsig_serial_buf rxsig_chk #(.MAX_CH(MAX_CH), .NIB_W(NIB_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .mode(mode), .mf_strobe(mf_strobe),
   .freeze(freeze), .pos_fbit(pos_fbit), .pos_ch(pos_ch),
   .pos_bit(pos_bit), .active(active), .sig_out(sig_out)
);

// File: tb/sim_rxsig_serial_buf.sv
module sim_rxsig_serial_buf;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] mode = 2'b00;
   logic       wr_en = 1'b0;
   logic [4:0] wr_ch = '0;
   logic [3:0] wr_nib = '0;
   logic       mf_strobe = 1'b0;
   logic       freeze = 1'b0;
   logic       pos_fbit = 1'b0;
   logic [4:0] pos_ch = '0;
   logic [2:0] pos_bit = '0;
   logic       sig_out;

   int total = 0;
   int bad = 0;

   always #4 clk = ~clk;

   rxsig_serial_buf u0 (
      .clk(clk), .rst_n(rst_n), .mode(mode), .wr_en(wr_en), .wr_ch(wr_ch),
      .wr_nib(wr_nib), .mf_strobe(mf_strobe), .freeze(freeze),
      .pos_fbit(pos_fbit), .pos_ch(pos_ch), .pos_bit(pos_bit),
      .sig_out(sig_out)
   );

   // {mode[1:0], fbit, ch[4:0], bit[2:0], expected}; nibble of ch = (5*ch+3) mod 16
   localparam int NV = 22;
   localparam logic [11:0] VEC [NV] = '{
      {2'b00, 1'b0, 5'd1,  3'd4, 1'b1},  // R3 ch1 1000 A
      {2'b00, 1'b0, 5'd1,  3'd5, 1'b0},  // R3 B
      {2'b00, 1'b0, 5'd2,  3'd4, 1'b1},  // R3 ch2 1101
      {2'b00, 1'b0, 5'd2,  3'd6, 1'b0},  // R3 C
      {2'b00, 1'b0, 5'd2,  3'd7, 1'b1},  // R3 D
      {2'b00, 1'b0, 5'd3,  3'd6, 1'b1},  // R3 ch3 0010 C
      {2'b01, 1'b0, 5'd3,  3'd6, 1'b0},  // R4 SF repeats A
      {2'b01, 1'b0, 5'd2,  3'd6, 1'b1},  // R4 ch2 A again
      {2'b01, 1'b0, 5'd2,  3'd7, 1'b1},  // R4 B again
      {2'b01, 1'b0, 5'd4,  3'd5, 1'b1},  // R4 ch4 0111 B
      {2'b01, 1'b0, 5'd4,  3'd6, 1'b0},  // R4 A not C
      {2'b01, 1'b0, 5'd4,  3'd7, 1'b1},  // R4 B not D
      {2'b10, 1'b0, 5'd0,  3'd7, 1'b0},  // R5 ts0 0011
      {2'b10, 1'b0, 5'd16, 3'd6, 1'b0},  // R5 ts16 0011
      {2'b10, 1'b0, 5'd17, 3'd4, 1'b1},  // R5 ts17 1000
      {2'b10, 1'b0, 5'd31, 3'd6, 1'b1},  // R5 ts31 1110
      {2'b10, 1'b1, 5'd31, 3'd7, 1'b0},  // R5 fbit ignored, D=0
      {2'b00, 1'b0, 5'd2,  3'd0, 1'b0},  // R6 upper nibble
      {2'b10, 1'b0, 5'd31, 3'd1, 1'b0},  // R6 upper nibble E1
      {2'b00, 1'b1, 5'd2,  3'd4, 1'b0},  // R7 framing bit
      {2'b00, 1'b0, 5'd26, 3'd5, 1'b0},  // R7 T1 ch26 0101
      {2'b10, 1'b0, 5'd26, 3'd5, 1'b1}   // R5 E1 ts26 B
   };

   task automatic chk(input logic exp, input string req);
      total++;
      if (sig_out !== exp) begin
         bad++;
         $display("FAIL %s: sig_out=%0b expected=%0b", req, sig_out, exp);
      end
   endtask

   // drive a position at a negedge, sample one clock later (R2)
   task automatic probe(input logic [1:0] m, input logic f, input logic [4:0] c,
                        input logic [2:0] b, input logic exp, input string req);
      @(negedge clk);
      mode = m; pos_fbit = f; pos_ch = c; pos_bit = b;
      @(negedge clk);
      chk(exp, req);
   endtask

   task automatic wr(input logic [4:0] c, input logic [3:0] n, input logic strobe,
                     input logic frz);
      @(negedge clk);
      wr_en = 1'b1; wr_ch = c; wr_nib = n; mf_strobe = strobe; freeze = frz;
      @(negedge clk);
      wr_en = 1'b0; mf_strobe = 1'b0; freeze = 1'b0;
   endtask

   task automatic strobe(input logic frz);
      @(negedge clk);
      mf_strobe = 1'b1; freeze = frz;
      @(negedge clk);
      mf_strobe = 1'b0; freeze = 1'b0;
   endtask

   initial begin
      mode = 2'b00; pos_ch = 5'd1; pos_bit = 3'd4;
      repeat (3) @(negedge clk);
      chk(1'b0, "R1 in reset");
      rst_n = 1'b1;
      @(negedge clk);
      chk(1'b0, "R1 after release");
      strobe(1'b0);
      probe(2'b00, 1'b0, 5'd1, 3'd4, 1'b0, "R1 cleared buffer");

      for (int c = 0; c < 32; c++) wr(5'(c), 4'((5*c+3) % 16), 1'b0, 1'b0);
      probe(2'b00, 1'b0, 5'd2, 3'd4, 1'b0, "R8 shadow not yet visible");
      strobe(1'b0);

      for (int i = 0; i < NV; i++) begin
         logic [11:0] v;
         v = VEC[i];
         probe(v[11:10], v[9], v[8:4], v[3:1], v[0], $sformatf("R2 vector %0d", i));
      end

      // R8: write without strobe invisible, then visible after strobe
      wr(5'd1, 4'b0111, 1'b0, 1'b0);
      probe(2'b00, 1'b0, 5'd1, 3'd4, 1'b1, "R8 old A kept");
      probe(2'b00, 1'b0, 5'd1, 3'd5, 1'b0, "R8 old B kept");
      strobe(1'b0);
      probe(2'b00, 1'b0, 5'd1, 3'd4, 1'b0, "R8 new A");
      probe(2'b00, 1'b0, 5'd1, 3'd5, 1'b1, "R8 new B");

      // R9: frozen strobe keeps old; later strobe transfers pending
      wr(5'd1, 4'b1000, 1'b0, 1'b0);
      strobe(1'b1);
      probe(2'b00, 1'b0, 5'd1, 3'd5, 1'b1, "R9 freeze holds");
      probe(2'b00, 1'b0, 5'd1, 3'd4, 1'b0, "R9 freeze holds A");
      strobe(1'b0);
      probe(2'b00, 1'b0, 5'd1, 3'd4, 1'b1, "R9 pending transferred");

      // R10: write in strobe cycle goes to shadow only
      wr(5'd2, 4'b0000, 1'b1, 1'b0);
      probe(2'b00, 1'b0, 5'd2, 3'd4, 1'b1, "R10 same-cycle write hidden");
      strobe(1'b0);
      probe(2'b00, 1'b0, 5'd2, 3'd4, 1'b0, "R10 appears next strobe");
      probe(2'b00, 1'b0, 5'd2, 3'd7, 1'b0, "R10 D cleared");

      probe(2'b11, 1'b0, 5'd31, 3'd6, 1'b0, "R5 mode off");

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: sig_out=%0b expected=done", sig_out);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule